// File: doc/BRIEF.md
# Interrupt Source State Controller

This block manages a small, parameterised set of interrupt inputs and offers their interrupts to one presentation unit. Each input is either level-sensitive or message-type (a rising edge is one event); the kind of every input is fixed by a parameter vector. For each input the block keeps a destination server, a priority, a saved priority and four status flags: asserted, sent, rejected and masked-pending. A priority of 0xFF masks the input.

The presentation unit sees one offer at a time on a valid/ready port. An offer carries the global source number (local index plus a base of 4096), the server and the priority. The presentation unit may send back reject and end-of-interrupt (EOI) requests tagged with global numbers, and it may ask for a resend. A resend is served by a scan that visits one source per cycle. Software programs each source through a single-cycle configuration write port that is addressed by local index.

Top module: `isc_top`

## Requirements
- R1: After reset no offer is presented. Every source is masked (priority 0xFF), and all flags and servers are cleared. A level line that is raised on a source that has not been configured produces no offer.
- R2: A rising edge on an unmasked message source offers it once. The offer carries global number 4096+index and the configured server and priority.
- R3: A rising edge on a masked message source sets its masked-pending flag and produces no offer. A later configuration write with priority 0xFF keeps the flag. A write with any other priority clears the flag and delivers exactly one offer.
- R4: A change on a level line updates the asserted flag. When the source is unmasked, asserted and not sent, it is offered and marked sent. While it is sent, no further offer is made.
- R5: A reject of a message source sets its rejected flag. The next resend clears the flag and offers the source once if it is unmasked. A later resend offers nothing.
- R6: A reject of a level source clears its sent flag, so that a resend re-offers it while its line is still asserted. A reject that lands in the same cycle as the scan visit to that source takes effect before the visit.
- R7: An EOI clears the sent flag of a level source and makes no offer by itself. An EOI addressed to a message source changes nothing.
- R8: A configuration write to a level source applies the level offer rule with the new priority. Unmasking an asserted source that has not been sent offers it.
- R9: At most one offer is presented per cycle, and the lowest pending index goes first. An offer stays valid until it is accepted, and its priority is never 0xFF.
- R10: A resend scan visits index i in the (i+1)-th cycle after the request, so it covers all sources in NUM_SRC cycles. A resend that arrives during a scan starts one further full scan straight after the current one.
- R11: A reject or EOI whose number lies outside 4096..4096+NUM_SRC-1 is ignored.
- R12: When an input event and a configuration write hit the same source in one cycle, the event is evaluated against the old priority first, and the write is applied after it. A masked message edge paired with an unmasking write therefore yields exactly one offer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Interrupt input lines |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Local index of the source being written |
| cfg_server_i | input | SRV_W | New destination server |
| cfg_prio_i | input | 8 | New priority (0xFF masks) |
| cfg_saved_prio_i | input | 8 | New saved priority |
| offer_valid_o | output | 1 | An offer is presented |
| offer_ready_i | input | 1 | The presentation unit accepts the offer |
| offer_num_o | output | NUM_W | Global source number of the offer |
| offer_server_o | output | SRV_W | Server of the offer |
| offer_prio_o | output | 8 | Priority of the offer |
| rej_valid_i | input | 1 | Reject request |
| rej_num_i | input | NUM_W | Global number to reject |
| eoi_valid_i | input | 1 | EOI request |
| eoi_num_i | input | NUM_W | Global number for the EOI |
| resend_i | input | 1 | Resend request |

## Verification
Two pairs of functions can touch the same source in one cycle. The first pair is an input edge and a configuration write. The bench raises a masked message line on the same edge as a write that unmasks the source. It expects exactly one offer, and it expects no second offer after a repeat write. The second pair is a reject and the resend scan visit. The bench counts scan cycles so that a reject of an asserted, sent level source arrives on the edge where the scan visits that index. It expects the offer to be valid immediately after that edge.

// File: rtl/isc_pkg.sv
package isc_pkg;
  typedef logic [7:0] prio_t;
  localparam prio_t PRIO_MASKED = 8'hFF;

  typedef struct packed {
    logic asserted;
    logic sent;
    logic rejected;
    logic mpend;
  } src_flags_t;
endpackage

// File: rtl/isc_src_slot.sv
module isc_src_slot
  import isc_pkg::*;
#(
  parameter int unsigned SRV_W    = 8,
  parameter bit          IS_LEVEL = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  input  logic             cfg_we_i,
  input  logic [SRV_W-1:0] cfg_server_i,
  input  prio_t            cfg_prio_i,
  input  prio_t            cfg_saved_i,
  input  logic             rej_i,
  input  logic             eoi_i,
  input  logic             visit_i,
  input  logic             take_i,
  output logic             offer_o,
  output logic [SRV_W-1:0] server_o,
  output prio_t            prio_o
);
  src_flags_t       f_q, f_d;
  prio_t            prio_q, prio_d, saved_q, saved_d;
  logic [SRV_W-1:0] srv_q, srv_d;
  logic             off_q, off_d, line_q;

  always_comb begin
    f_d     = f_q;
    prio_d  = prio_q;
    saved_d = saved_q;
    srv_d   = srv_q;
    off_d   = off_q & ~take_i;
    if (rej_i) begin
      if (IS_LEVEL) f_d.sent = 1'b0;
      else          f_d.rejected = 1'b1;
    end
    if (eoi_i && IS_LEVEL) f_d.sent = 1'b0;
    // input event sees the priority held before any same-cycle write
    if (IS_LEVEL) begin
      if (line_i != line_q) f_d.asserted = line_i;
    end else if (line_i && !line_q) begin
      if (prio_q == PRIO_MASKED) f_d.mpend = 1'b1;
      else                       off_d = 1'b1;
    end
    if (cfg_we_i) begin
      srv_d   = cfg_server_i;
      prio_d  = cfg_prio_i;
      saved_d = cfg_saved_i;
      if (cfg_prio_i == PRIO_MASKED) off_d = 1'b0;
      else if (!IS_LEVEL && f_d.mpend) begin
        f_d.mpend = 1'b0;
        off_d     = 1'b1;
      end
    end
    if (visit_i && !IS_LEVEL && f_d.rejected) begin
      f_d.rejected = 1'b0;
      if (prio_d != PRIO_MASKED) off_d = 1'b1;
    end
    // level rule, once, after all updates of this cycle
    if (IS_LEVEL && ((line_i != line_q) || cfg_we_i || visit_i) &&
        prio_d != PRIO_MASKED && f_d.asserted && !f_d.sent) begin
      f_d.sent = 1'b1;
      off_d    = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_q     <= '0;
      prio_q  <= PRIO_MASKED;
      saved_q <= PRIO_MASKED;
      srv_q   <= '0;
      off_q   <= 1'b0;
      line_q  <= 1'b0;
    end else begin
      f_q     <= f_d;
      prio_q  <= prio_d;
      saved_q <= saved_d;
      srv_q   <= srv_d;
      off_q   <= off_d;
      line_q  <= line_i;
    end
  end

  assign offer_o  = off_q;
  assign server_o = srv_q;
  assign prio_o   = prio_q;

  p_pend_masked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    f_q.mpend |-> prio_q == PRIO_MASKED);
endmodule

// File: rtl/isc_offer_arb.sv
module isc_offer_arb #(
  parameter int unsigned N = 16,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign valid_o = |req_i;
endmodule

// File: rtl/isc_resend_scan.sv
module isc_resend_scan #(
  parameter int unsigned N = 16,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             resend_i,
  output logic             active_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);
  logic             active_q, again_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      again_q  <= 1'b0;
      idx_q    <= '0;
    end else if (active_q) begin
      if (idx_q == LAST) begin
        idx_q <= '0;
        if (again_q || resend_i) again_q  <= 1'b0;
        else                     active_q <= 1'b0;
      end else begin
        idx_q <= idx_q + 1'b1;
        if (resend_i) again_q <= 1'b1;
      end
    end else if (resend_i) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end
  end

  assign active_o = active_q;
  assign idx_o    = idx_q;

  p_scan_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q && resend_i |=> active_q && idx_q == '0);
  p_scan_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && idx_q == LAST && !again_q && !resend_i |=> !active_q);
endmodule

// File: rtl/isc_top.sv
module isc_top
  import isc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned BASE    = 4096,
  parameter int unsigned NUM_W   = 16,
  parameter int unsigned SRV_W   = 8,
  parameter logic [NUM_SRC-1:0] SRC_IS_LEVEL = 16'h00F0,
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               cfg_we_i,
  input  logic [IDX_W-1:0]   cfg_idx_i,
  input  logic [SRV_W-1:0]   cfg_server_i,
  input  logic [7:0]         cfg_prio_i,
  input  logic [7:0]         cfg_saved_prio_i,
  output logic               offer_valid_o,
  input  logic               offer_ready_i,
  output logic [NUM_W-1:0]   offer_num_o,
  output logic [SRV_W-1:0]   offer_server_o,
  output logic [7:0]         offer_prio_o,
  input  logic               rej_valid_i,
  input  logic [NUM_W-1:0]   rej_num_i,
  input  logic               eoi_valid_i,
  input  logic [NUM_W-1:0]   eoi_num_i,
  input  logic               resend_i
);
  localparam logic [NUM_W-1:0] BASE_N = NUM_W'(BASE);
  localparam logic [NUM_W-1:0] LIM_N  = NUM_W'(BASE + NUM_SRC);

  logic [NUM_W-1:0] rej_off, eoi_off;
  logic             rej_in, eoi_in, scan_act;
  logic [IDX_W-1:0] scan_idx, gnt_idx;
  logic [NUM_SRC-1:0] offer_v;
  logic [SRV_W-1:0] srv_v  [NUM_SRC];
  prio_t            prio_v [NUM_SRC];

  // global number -> local index, out-of-range requests dropped
  assign rej_off = rej_num_i - BASE_N;
  assign eoi_off = eoi_num_i - BASE_N;
  assign rej_in  = rej_valid_i && rej_num_i >= BASE_N && rej_num_i < LIM_N;
  assign eoi_in  = eoi_valid_i && eoi_num_i >= BASE_N && eoi_num_i < LIM_N;

  isc_resend_scan #(.N(NUM_SRC)) u_scan (
    .clk_i, .rst_ni, .resend_i, .active_o(scan_act), .idx_o(scan_idx)
  );

  isc_offer_arb #(.N(NUM_SRC)) u_arb (
    .req_i(offer_v), .valid_o(offer_valid_o), .idx_o(gnt_idx)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam logic [IDX_W-1:0] ME = IDX_W'(i);
    isc_src_slot #(.SRV_W(SRV_W), .IS_LEVEL(SRC_IS_LEVEL[i])) u_slot (
      .clk_i,
      .rst_ni,
      .line_i       (src_i[i]),
      .cfg_we_i     (cfg_we_i && cfg_idx_i == ME),
      .cfg_server_i,
      .cfg_prio_i,
      .cfg_saved_i  (cfg_saved_prio_i),
      .rej_i        (rej_in && rej_off[IDX_W-1:0] == ME),
      .eoi_i        (eoi_in && eoi_off[IDX_W-1:0] == ME),
      .visit_i      (scan_act && scan_idx == ME),
      .take_i       (offer_valid_o && offer_ready_i && gnt_idx == ME),
      .offer_o      (offer_v[i]),
      .server_o     (srv_v[i]),
      .prio_o       (prio_v[i])
    );
  end

  assign offer_num_o    = BASE_N + NUM_W'(gnt_idx);
  assign offer_server_o = srv_v[gnt_idx];
  assign offer_prio_o   = prio_v[gnt_idx];

  p_hold_offer_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    offer_valid_o && !offer_ready_i && !cfg_we_i |=> offer_valid_o);
  p_unmasked_offer_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    offer_valid_o |-> offer_prio_o != PRIO_MASKED);
endmodule

// File: tb/isc_top_tb_top.sv
module isc_top_tb_top;
  localparam int N = 16;
  localparam int BASE = 4096;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] src_i = '0;
  logic cfg_we_i = 1'b0;
  logic [3:0] cfg_idx_i = '0;
  logic [7:0] cfg_server_i = '0, cfg_prio_i = '0, cfg_saved_prio_i = '0;
  logic offer_valid_o, offer_ready_i = 1'b0;
  logic [15:0] offer_num_o;
  logic [7:0] offer_server_o, offer_prio_o;
  logic rej_valid_i = 1'b0, eoi_valid_i = 1'b0, resend_i = 1'b0;
  logic [15:0] rej_num_i = '0, eoi_num_i = '0;

  int errs = 0;
  int checks = 0;

  always #4 clk_i = ~clk_i;

  isc_top dut_i (.*);

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_offer(input int idx, input int srv, input int prio, input string tag);
    check(offer_valid_o == 1'b1, {tag, " valid"}, int'(offer_valid_o), 1);
    check(offer_num_o == 16'(BASE + idx), {tag, " num"}, int'(offer_num_o), BASE + idx);
    if (srv >= 0) check(offer_server_o == 8'(srv), {tag, " server"}, int'(offer_server_o), srv);
    if (prio >= 0) check(offer_prio_o == 8'(prio), {tag, " prio"}, int'(offer_prio_o), prio);
  endtask

  task automatic expect_none(input string tag);
    check(offer_valid_o == 1'b0, {tag, " no offer"}, int'(offer_valid_o), 0);
  endtask

  task automatic take();
    offer_ready_i = 1'b1; tick(); offer_ready_i = 1'b0;
  endtask

  task automatic cfg(input int idx, input int srv, input int prio);
    cfg_we_i = 1'b1; cfg_idx_i = 4'(idx); cfg_server_i = 8'(srv);
    cfg_prio_i = 8'(prio); cfg_saved_prio_i = 8'(prio);
    tick(); cfg_we_i = 1'b0;
  endtask

  task automatic pulse(input int idx);
    src_i[idx] = 1'b1; tick(); src_i[idx] = 1'b0;
  endtask

  task automatic reject(input int num);
    rej_valid_i = 1'b1; rej_num_i = 16'(num); tick(); rej_valid_i = 1'b0;
  endtask

  task automatic eoi(input int num);
    eoi_valid_i = 1'b1; eoi_num_i = 16'(num); tick(); eoi_valid_i = 1'b0;
  endtask

  task automatic resend_wait();
    resend_i = 1'b1; tick(); resend_i = 1'b0;
    repeat (N + 1) tick();
  endtask

  task automatic t_reset();
    expect_none("R1 after reset");
    src_i[4] = 1'b1; tick();
    expect_none("R1 level raised on masked source");
    src_i[4] = 1'b0; tick();
  endtask

  task automatic t_msg();
    cfg(12, 3, 5);
    pulse(12);
    expect_offer(12, 3, 5, "R2 message edge");
    take();
    expect_none("R2 single offer");
  endtask

  task automatic t_masked();
    pulse(13);
    expect_none("R3 masked edge");
    cfg(13, 1, 255);
    expect_none("R3 still masked");
    cfg(13, 1, 2);
    expect_offer(13, 1, 2, "R3 unmask delivers");
    take();
    cfg(13, 1, 2);
    expect_none("R3 pending flag cleared");
  endtask

  task automatic t_level();
    cfg(4, 1, 4);
    src_i[4] = 1'b1; tick();
    expect_offer(4, 1, 4, "R4 level offer");
    take();
    resend_wait();
    expect_none("R4 sent blocks re-offer");
    eoi(BASE + 4);
    expect_none("R7 eoi alone no offer");
    resend_wait();
    expect_offer(4, 1, 4, "R7 eoi then resend");
    take();
    reject(BASE + 4);
    resend_wait();
    expect_offer(4, 1, 4, "R6 level reject then resend");
    take();
    src_i[4] = 1'b0; tick();
    eoi(BASE + 12);
    resend_wait();
    expect_none("R7 eoi on message no effect");
  endtask

  task automatic t_msg_reject();
    pulse(12);
    expect_offer(12, 3, 5, "R5 offer");
    take();
    reject(BASE + 12);
    expect_none("R5 reject no offer");
    resend_wait();
    expect_offer(12, 3, 5, "R5 resend re-offers");
    take();
    resend_wait();
    expect_none("R5 flag cleared");
  endtask

  task automatic t_level_cfg();
    src_i[5] = 1'b1; tick();
    expect_none("R8 masked level");
    cfg(5, 2, 1);
    expect_offer(5, 2, 1, "R8 unmask asserted level");
    take();
    src_i[5] = 1'b0; tick();
  endtask

  task automatic t_arb();
    cfg(10, 4, 3);
    cfg(11, 5, 3);
    src_i[10] = 1'b1; src_i[11] = 1'b1; tick(); src_i[10] = 1'b0; src_i[11] = 1'b0;
    expect_offer(10, 4, 3, "R9 lowest first");
    tick(); tick();
    expect_offer(10, 4, 3, "R9 held until ready");
    take();
    expect_offer(11, 5, 3, "R9 second offer");
    take();
    expect_none("R9 drained");
  endtask

  task automatic t_scan();
    cfg(15, 6, 6);
    pulse(15);
    take();
    reject(BASE + 15);
    resend_i = 1'b1; tick(); resend_i = 1'b0;   // edge k
    repeat (15) tick();                          // edge k+15
    expect_none("R10 before last visit");
    tick();                                      // edge k+16
    expect_offer(15, 6, 6, "R10 visit at cycle 16");
    take();
    reject(BASE + 15);
    resend_i = 1'b1; tick(); resend_i = 1'b0;   // edge k
    repeat (4) tick();
    resend_i = 1'b1; tick(); resend_i = 1'b0;   // edge k+5, queued scan
    repeat (11) tick();                          // edge k+16
    expect_offer(15, 6, 6, "R10 first scan");
    take();                                      // k+17
    reject(BASE + 15);                           // k+18
    repeat (13) tick();                          // k+31
    expect_none("R10 second scan not yet at last");
    tick();                                      // k+32
    expect_offer(15, 6, 6, "R10 queued scan");
    take();
  endtask

  task automatic t_range();
    cfg(0, 7, 7);
    pulse(0);
    take();
    reject(BASE + N);
    reject(BASE - 1);
    resend_wait();
    expect_none("R11 out of range ignored");
    reject(BASE);
    resend_wait();
    expect_offer(0, 7, 7, "R11 in range accepted");
    take();
  endtask

  task automatic t_same_cycle();
    src_i[9] = 1'b1;
    cfg(9, 2, 2);
    src_i[9] = 1'b0;
    expect_offer(9, 2, 2, "R12 edge with unmask");
    take();
    expect_none("R12 exactly one offer");
    cfg(9, 2, 2);
    expect_none("R12 no pending left");
    cfg(6, 3, 9);
    src_i[6] = 1'b1; tick();
    expect_offer(6, 3, 9, "R6 level offer");
    take();
    resend_i = 1'b1; tick(); resend_i = 1'b0;   // edge k
    repeat (6) tick();                           // edge k+6
    reject(BASE + 6);                            // edge k+7, visit of index 6
    expect_offer(6, 3, 9, "R6 reject with scan visit");
    take();
    src_i[6] = 1'b0;
    repeat (N + 2) tick();
  endtask

  initial begin
    #(200000 * 8);
    errs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_msg();
    t_masked();
    t_level();
    t_msg_reject();
    t_level_cfg();
    t_arb();
    t_scan();
    t_range();
    t_same_cycle();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule